// File: doc/BRIEF.md
# I2C Target Address Recognition Unit

This unit watches a two-wire serial bus on behalf of a target device. After every START it collects the first byte, which is a 7-bit address followed by a read/write bit, and decides whether the byte is meant for this device. It has four programmable address slots. In direct mode each slot is a separate address. In paired mode the slots form two address/mask pairs. When an address matches, the unit raises its status flags and steers the byte either to an address holding register or to a receive buffer. It can also stall the bus clock during the acknowledge phase, so that software can choose whether to acknowledge.

The bus lines enter unsynchronized and are resampled inside the block. The unit drives two open-drain pull-down requests, one for SCL and one for SDA. Configuration, clear strobes and status flags are plain level pins. Each accepted address is also offered on a valid/ready event stream. The event is raised in the cycle the match is taken and held with stable data until a cycle in which `evt_ready` is high. A match that arrives while an event is still pending updates all the status flags but leaves the pending event and its data untouched.

Top module: `i2c_addr_recog`

## Requirements
- R1: A falling SDA while SCL is high is a START. It sets `start_flag`, which stays set until a `clr_start` strobe. A START also clears `target_active` and restarts address collection.
- R2: Address bits are sampled on rising SCL, most significant bit first. The eighth bit is the read/write bit, and 1 means read.
- R3: With `cfg_mask_mode`=0, the upper seven bits of the byte are compared with each of the four 7-bit slots in `cfg_slots` (slot k sits in bits 7k+6..7k). Equality with any slot is a match.
- R4: With `cfg_mask_mode`=1, slot 1 masks the comparison against slot 0 and slot 3 masks the comparison against slot 2. A mask bit of 1 makes that address bit a don't-care. In this mode slots 1 and 3 are never addresses themselves.
- R5: On a match, `target_active` goes to 1, `read_flag` takes the read/write bit, `data_flag` goes to 0, and `addr_flag` goes to 1 until a `clr_addr` strobe.
- R6: With `cfg_buf_sel`=0, the matched byte is loaded into `hold_addr` and the receive side is untouched. With `cfg_buf_sel`=1, the byte goes to `rx_byte` and sets `rx_full` and `rx_irq`, and `hold_addr` is untouched.
- R7: `rx_full` and `rx_irq` clear only on an `rx_read` or `clr_buf` strobe.
- R8: If no slot matches, the unit returns to idle. It does not acknowledge and leaves its flags alone. Later bus bytes are ignored until the next START.
- R9: If `cfg_hold_en`=1 and `cfg_stretch_dis`=0 at the SCL fall that ends the eighth bit, `stretch_flag` and `gen_irq` go to 1 and `scl_hold` keeps SCL low until a `clr_stretch` strobe. `gen_irq` falls once both `stretch_flag` and `addr_flag` are clear.
- R10: During the ninth clock of a matched address, `sda_pull` equals the inverse of `cfg_ack_data` (0 means acknowledge). It follows changes made while the clock is held.
- R11: When the ninth clock completes, `data_flag` goes to 1. A STOP (rising SDA while SCL is high) clears `target_active`.
- R12: `evt_valid` rises with a match carrying the matched byte on `evt_data`. The byte stays stable until `evt_ready` is sampled high, and then `evt_valid` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen on the wire |
| sda_in | input | 1 | Bus data line as seen on the wire |
| scl_hold | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull | output | 1 | 1 pulls SDA low (acknowledge) |
| cfg_slots | input | 28 | Four 7-bit address/mask slots |
| cfg_mask_mode | input | 1 | 0 direct slots, 1 masked pairs |
| cfg_buf_sel | input | 1 | 0 route to hold_addr, 1 route to receive buffer |
| cfg_hold_en | input | 1 | Hold the clock after an address match |
| cfg_stretch_dis | input | 1 | Forbid any clock stretching |
| cfg_ack_data | input | 1 | Acknowledge value, 0 = ACK |
| clr_start | input | 1 | Strobe clearing start_flag |
| clr_addr | input | 1 | Strobe clearing addr_flag |
| clr_stretch | input | 1 | Strobe clearing stretch_flag |
| clr_buf | input | 1 | Strobe emptying the receive buffer |
| rx_read | input | 1 | Strobe marking the receive buffer as read |
| start_flag | output | 1 | START seen |
| target_active | output | 1 | Addressed and no STOP/START since |
| read_flag | output | 1 | Read/write bit of the matched byte |
| data_flag | output | 1 | 0 after an address, 1 once its ninth clock ends |
| addr_flag | output | 1 | Address matched |
| stretch_flag | output | 1 | Clock stretch requested |
| gen_irq | output | 1 | General interrupt |
| rx_full | output | 1 | Receive buffer holds a byte |
| rx_irq | output | 1 | Receive interrupt |
| hold_addr | output | 8 | Matched byte (address route) |
| rx_byte | output | 8 | Matched byte (buffer route) |
| evt_valid | output | 1 | Address event valid |
| evt_ready | input | 1 | Address event accepted |
| evt_data | output | 8 | Address event byte |

## Verification
The bench sends an address whose bit-reversed form is not in any slot. A design that shifted least significant bit first would then stay silent. It sends a byte that equals a mask slot in paired mode, which a design that used the mask slots as addresses would acknowledge. After a failed match it sends a matching byte with no START in between, which a design that kept listening would take. During a held ninth clock it checks that the clock stays low and that changing the acknowledge bit changes SDA. A design that latched the acknowledge value, released the clock early, or dropped the general interrupt while the address flag was still set would show the wrong line level or flag.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_SETUP,
    ST_ACK_LOW,
    ST_ACK_HIGH,
    ST_ACTIVE
  } am_state_t;
endpackage

// File: rtl/i2c_am_linemon.sv
module i2c_am_linemon #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  // resample both lines through SYNC flops; idle bus reads high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC-2:0], scl_in};
      sda_ff <= {sda_ff[SYNC-2:0], sda_in};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s     = scl_ff[SYNC-1];
  assign sda_s     = sda_ff[SYNC-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp #(
  parameter int ADDR_W = 7,
  parameter int SLOTS  = 4
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic [SLOTS*ADDR_W-1:0] slots,
  input  logic                    mask_mode,
  output logic                    hit
);
  localparam int PAIRS = SLOTS / 2;

  logic [SLOTS-1:0] direct_hit;
  logic [PAIRS-1:0] pair_hit;

  for (genvar i = 0; i < SLOTS; i++) begin : g_direct
    assign direct_hit[i] = (addr == slots[i*ADDR_W +: ADDR_W]);
  end

  // even slot is the address, the odd slot after it is its don't-care mask
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic [ADDR_W-1:0] base, care;
    assign base        = slots[(2*p)*ADDR_W +: ADDR_W];
    assign care        = ~slots[(2*p+1)*ADDR_W +: ADDR_W];
    assign pair_hit[p] = (((addr ^ base) & care) == '0);
  end

  assign hit = mask_mode ? |pair_hit : |direct_hit;
endmodule

// File: rtl/i2c_am_ctrl.sv
module i2c_am_ctrl
  import i2c_am_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int BYTE_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              hit,
  output logic [ADDR_W-1:0] cmp_addr,
  input  logic              cfg_buf_sel,
  input  logic              cfg_hold_en,
  input  logic              cfg_stretch_dis,
  input  logic              cfg_ack_data,
  input  logic              clr_start,
  input  logic              clr_addr,
  input  logic              clr_stretch,
  input  logic              clr_buf,
  input  logic              rx_read,
  output logic              scl_hold,
  output logic              sda_pull,
  output logic              start_flag,
  output logic              target_active,
  output logic              read_flag,
  output logic              data_flag,
  output logic              addr_flag,
  output logic              stretch_flag,
  output logic              gen_irq,
  output logic              rx_full,
  output logic              rx_irq,
  output logic [BYTE_W-1:0] hold_addr,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              evt_valid,
  input  logic              evt_ready,
  output logic [BYTE_W-1:0] evt_data
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  am_state_t         st;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic bus_evt, match_now, miss_now, stretch_set, ack_done;

  assign cmp_addr    = shreg[BYTE_W-1:1];
  assign bus_evt     = start_det | stop_det;
  assign match_now   = (st == ST_ADDR) & ~bus_evt & ~scl_rise & (bit_cnt == FULL) & hit;
  assign miss_now    = (st == ST_ADDR) & ~bus_evt & ~scl_rise & (bit_cnt == FULL) & ~hit;
  assign stretch_set = (st == ST_ACK_SETUP) & ~bus_evt & scl_fall &
                       cfg_hold_en & ~cfg_stretch_dis & addr_flag;
  assign ack_done    = (st == ST_ACK_HIGH) & ~bus_evt & scl_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (start_det) begin
      st      <= ST_ADDR;
      bit_cnt <= '0;
    end else if (stop_det) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_ADDR: begin
          if (scl_rise) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (match_now) begin
            st <= ST_ACK_SETUP;
          end else if (miss_now) begin
            st <= ST_IDLE;
          end
        end
        ST_ACK_SETUP: if (scl_fall) st <= ST_ACK_LOW;
        ST_ACK_LOW:   if (scl_rise) st <= ST_ACK_HIGH;
        ST_ACK_HIGH:  if (scl_fall) st <= ST_ACTIVE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_flag    <= 1'b0;
      target_active <= 1'b0;
      read_flag     <= 1'b0;
      data_flag     <= 1'b0;
      addr_flag     <= 1'b0;
      stretch_flag  <= 1'b0;
      gen_irq       <= 1'b0;
      rx_full       <= 1'b0;
      rx_irq        <= 1'b0;
      hold_addr     <= '0;
      rx_byte       <= '0;
      evt_valid     <= 1'b0;
      evt_data      <= '0;
    end else begin
      if (start_det)      start_flag <= 1'b1;
      else if (clr_start) start_flag <= 1'b0;

      if (match_now)    target_active <= 1'b1;
      else if (bus_evt) target_active <= 1'b0;

      if (match_now) read_flag <= shreg[0];

      if (match_now)     data_flag <= 1'b0;
      else if (ack_done) data_flag <= 1'b1;

      if (match_now)     addr_flag <= 1'b1;
      else if (clr_addr) addr_flag <= 1'b0;

      if (stretch_set)      stretch_flag <= 1'b1;
      else if (clr_stretch) stretch_flag <= 1'b0;

      if (stretch_set)                      gen_irq <= 1'b1;
      else if (!stretch_flag && !addr_flag) gen_irq <= 1'b0;

      if (match_now && !cfg_buf_sel) hold_addr <= shreg;

      if (match_now && cfg_buf_sel) begin
        rx_byte <= shreg;
        rx_full <= 1'b1;
        rx_irq  <= 1'b1;
      end else if (rx_read || clr_buf) begin
        rx_full <= 1'b0;
        rx_irq  <= 1'b0;
      end

      // one-deep event slot: a pending event is never overwritten
      if (evt_valid) begin
        if (evt_ready) evt_valid <= 1'b0;
      end else if (match_now) begin
        evt_valid <= 1'b1;
        evt_data  <= shreg;
      end
    end
  end

  assign scl_hold = stretch_flag & (st == ST_ACK_LOW);
  assign sda_pull = ((st == ST_ACK_LOW) | (st == ST_ACK_HIGH)) & ~cfg_ack_data;
endmodule

// File: rtl/i2c_addr_recog.sv
module i2c_addr_recog #(
  parameter int ADDR_W = 7,
  parameter int SLOTS  = 4,
  parameter int SYNC   = 2,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_in,
  input  logic                    sda_in,
  output logic                    scl_hold,
  output logic                    sda_pull,
  input  logic [SLOTS*ADDR_W-1:0] cfg_slots,
  input  logic                    cfg_mask_mode,
  input  logic                    cfg_buf_sel,
  input  logic                    cfg_hold_en,
  input  logic                    cfg_stretch_dis,
  input  logic                    cfg_ack_data,
  input  logic                    clr_start,
  input  logic                    clr_addr,
  input  logic                    clr_stretch,
  input  logic                    clr_buf,
  input  logic                    rx_read,
  output logic                    start_flag,
  output logic                    target_active,
  output logic                    read_flag,
  output logic                    data_flag,
  output logic                    addr_flag,
  output logic                    stretch_flag,
  output logic                    gen_irq,
  output logic                    rx_full,
  output logic                    rx_irq,
  output logic [BYTE_W-1:0]       hold_addr,
  output logic [BYTE_W-1:0]       rx_byte,
  output logic                    evt_valid,
  input  logic                    evt_ready,
  output logic [BYTE_W-1:0]       evt_data
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det, hit;
  logic [ADDR_W-1:0] cmp_addr;

  i2c_am_linemon #(.SYNC(SYNC)) u_linemon (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_am_cmp #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_cmp (
    .addr(cmp_addr), .slots(cfg_slots), .mask_mode(cfg_mask_mode), .hit(hit)
  );

  i2c_am_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .hit(hit), .cmp_addr(cmp_addr),
    .cfg_buf_sel(cfg_buf_sel), .cfg_hold_en(cfg_hold_en),
    .cfg_stretch_dis(cfg_stretch_dis), .cfg_ack_data(cfg_ack_data),
    .clr_start(clr_start), .clr_addr(clr_addr), .clr_stretch(clr_stretch),
    .clr_buf(clr_buf), .rx_read(rx_read),
    .scl_hold(scl_hold), .sda_pull(sda_pull),
    .start_flag(start_flag), .target_active(target_active),
    .read_flag(read_flag), .data_flag(data_flag), .addr_flag(addr_flag),
    .stretch_flag(stretch_flag), .gen_irq(gen_irq),
    .rx_full(rx_full), .rx_irq(rx_irq),
    .hold_addr(hold_addr), .rx_byte(rx_byte),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_data(evt_data)
  );
endmodule

// File: rtl/i2c_addr_recog_chk.sv
module i2c_addr_recog_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_hold,
  input logic              sda_pull,
  input logic              start_flag,
  input logic              clr_start,
  input logic              target_active,
  input logic              addr_flag,
  input logic              data_flag,
  input logic              stretch_flag,
  input logic              rx_irq,
  input logic              rx_read,
  input logic              clr_buf,
  input logic              evt_valid,
  input logic              evt_ready,
  input logic [BYTE_W-1:0] evt_data
);
  // R1
  start_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_flag && !clr_start |=> start_flag);

  // R5
  addr_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_flag) |-> target_active && !data_flag);

  // R7
  rx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq && !rx_read && !clr_buf |=> rx_irq);

  // R9
  hold_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold |-> target_active && stretch_flag);

  // R10
  ack_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> target_active);

  // R12
  evt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |=> evt_valid && $stable(evt_data));
endmodule

bind i2c_addr_recog i2c_addr_recog_chk u_chk (.*);

// File: tb/i2c_addr_recog_bench.sv
module i2c_addr_recog_bench;
  localparam int H = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_scl = 1'b1, host_sda = 1'b1;
  logic [27:0] cfg_slots = '0;
  logic cfg_mask_mode = 0, cfg_buf_sel = 0, cfg_hold_en = 0;
  logic cfg_stretch_dis = 0, cfg_ack_data = 0;
  logic clr_start = 0, clr_addr = 0, clr_stretch = 0, clr_buf = 0, rx_read = 0;
  logic evt_ready = 0;
  logic scl_hold, sda_pull, start_flag, target_active, read_flag, data_flag;
  logic addr_flag, stretch_flag, gen_irq, rx_full, rx_irq, evt_valid;
  logic [7:0] hold_addr, rx_byte, evt_data;
  logic scl_line, sda_line;
  int vectors = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign scl_line = host_scl & ~scl_hold;
  assign sda_line = host_sda & ~sda_pull;

  i2c_addr_recog u_i2c_addr_recog (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .scl_hold(scl_hold), .sda_pull(sda_pull), .cfg_slots(cfg_slots),
    .cfg_mask_mode(cfg_mask_mode), .cfg_buf_sel(cfg_buf_sel),
    .cfg_hold_en(cfg_hold_en), .cfg_stretch_dis(cfg_stretch_dis),
    .cfg_ack_data(cfg_ack_data), .clr_start(clr_start), .clr_addr(clr_addr),
    .clr_stretch(clr_stretch), .clr_buf(clr_buf), .rx_read(rx_read),
    .start_flag(start_flag), .target_active(target_active),
    .read_flag(read_flag), .data_flag(data_flag), .addr_flag(addr_flag),
    .stretch_flag(stretch_flag), .gen_irq(gen_irq), .rx_full(rx_full),
    .rx_irq(rx_irq), .hold_addr(hold_addr), .rx_byte(rx_byte),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_data(evt_data)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic bus_start();
    host_sda = 1; tick(H); host_scl = 1; tick(H);
    host_sda = 0; tick(H); host_scl = 0; tick(H);
  endtask

  task automatic bus_stop();
    host_sda = 0; tick(H); host_scl = 1; tick(H); host_sda = 1; tick(H);
  endtask

  task automatic bus_bit(input logic b);
    host_sda = b; tick(H); host_scl = 1;
    wait (scl_line == 1'b1);
    tick(H); host_scl = 0; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bus_bit(v[i]);
  endtask

  task automatic ninth(output logic ackv);
    host_sda = 1; tick(H); host_scl = 1;
    wait (scl_line == 1'b1);
    tick(H/2); ackv = sda_line; tick(H/2);
    host_scl = 0; tick(H);
  endtask

  task automatic strobe_addr_start();
    clr_addr = 1; clr_start = 1; tick(1); clr_addr = 0; clr_start = 0; tick(2);
  endtask

  task automatic t_reset();
    chk("R1 start_flag at reset", {7'b0, start_flag}, 8'h00);
    chk("R5 addr_flag at reset", {7'b0, addr_flag}, 8'h00);
    chk("R9 scl_hold at reset", {7'b0, scl_hold}, 8'h00);
    chk("R12 evt_valid at reset", {7'b0, evt_valid}, 8'h00);
  endtask

  // R2 R3 R5 R6 R10 R11 R12: direct-mode match, address route
  task automatic t_direct();
    logic a;
    cfg_slots = {7'h78, 7'h56, 7'h34, 7'h12};
    bus_start();
    chk("R1 start sets flag", {7'b0, start_flag}, 8'h01);
    send_byte(8'hAD); // addr 0x56, read; reversed byte would be addr 0x5A
    chk("R3 R2 addr_flag on slot2", {7'b0, addr_flag}, 8'h01);
    chk("R5 target_active", {7'b0, target_active}, 8'h01);
    chk("R5 read_flag", {7'b0, read_flag}, 8'h01);
    chk("R5 data_flag cleared", {7'b0, data_flag}, 8'h00);
    chk("R6 hold_addr", hold_addr, 8'hAD);
    chk("R6 rx_full untouched", {7'b0, rx_full}, 8'h00);
    chk("R12 evt_valid", {7'b0, evt_valid}, 8'h01);
    ninth(a);
    chk("R10 ack driven", {7'b0, a}, 8'h00);
    chk("R11 data_flag after ninth", {7'b0, data_flag}, 8'h01);
    chk("R12 evt_data held", evt_data, 8'hAD);
    bus_stop();
    chk("R11 stop clears target_active", {7'b0, target_active}, 8'h00);
    evt_ready = 1; tick(1); evt_ready = 0; tick(1);
    chk("R12 evt_valid after ready", {7'b0, evt_valid}, 8'h00);
    chk("R1 start_flag persists", {7'b0, start_flag}, 8'h01);
    strobe_addr_start();
    chk("R1 clr_start clears", {7'b0, start_flag}, 8'h00);
  endtask

  // R8: miss, then a matching byte with no START in between
  task automatic t_miss();
    logic a;
    bus_start();
    send_byte(8'h22); // addr 0x11
    chk("R8 no addr_flag on miss", {7'b0, addr_flag}, 8'h00);
    ninth(a);
    chk("R8 no ack on miss", {7'b0, a}, 8'h01);
    send_byte(8'h24); // addr 0x12 without START
    chk("R8 ignored until START", {7'b0, addr_flag}, 8'h00);
    ninth(a);
    chk("R8 stray byte not acked", {7'b0, a}, 8'h01);
    chk("R8 no event", {7'b0, evt_valid}, 8'h00);
    bus_stop();
    strobe_addr_start();
  endtask

  // R4 R6 R7: masked pairs, buffer route
  task automatic t_masked();
    logic a;
    evt_ready = 1;
    cfg_mask_mode = 1; cfg_buf_sel = 1;
    cfg_slots = {7'h00, 7'h20, 7'h0F, 7'h50};
    bus_start();
    send_byte(8'hB4); // addr 0x5A, write: pair 0 under mask
    chk("R4 pair0 masked match", {7'b0, addr_flag}, 8'h01);
    chk("R5 read_flag write", {7'b0, read_flag}, 8'h00);
    chk("R6 rx_byte", rx_byte, 8'hB4);
    chk("R6 rx_full", {7'b0, rx_full}, 8'h01);
    chk("R6 rx_irq", {7'b0, rx_irq}, 8'h01);
    chk("R6 hold_addr untouched", hold_addr, 8'hAD);
    ninth(a);
    bus_stop();
    strobe_addr_start();
    chk("R7 rx_irq survives other clears", {7'b0, rx_irq}, 8'h01);
    rx_read = 1; tick(1); rx_read = 0; tick(1);
    chk("R7 rx_read clears rx_irq", {7'b0, rx_irq}, 8'h00);
    chk("R7 rx_read clears rx_full", {7'b0, rx_full}, 8'h00);
    bus_start();
    send_byte(8'h1E); // addr 0x0F = mask slot, must not match
    chk("R4 mask slot not an address", {7'b0, addr_flag}, 8'h00);
    ninth(a);
    bus_stop();
    bus_start();
    send_byte(8'h41); // addr 0x20 exact, pair 1
    chk("R4 pair1 match", {7'b0, addr_flag}, 8'h01);
    chk("R6 rx_byte pair1", rx_byte, 8'h41);
    ninth(a);
    bus_stop();
    clr_buf = 1; tick(1); clr_buf = 0; tick(1);
    chk("R7 clr_buf clears rx_full", {7'b0, rx_full}, 8'h00);
    strobe_addr_start();
    cfg_mask_mode = 0; cfg_buf_sel = 0;
  endtask

  // R9 R10: clock held on the ninth clock, ack chosen during the hold
  task automatic t_stretch();
    logic a;
    cfg_slots = {7'h78, 7'h56, 7'h34, 7'h12};
    cfg_hold_en = 1; cfg_ack_data = 1;
    bus_start();
    send_byte(8'hF0); // addr 0x78, write
    chk("R9 stretch_flag", {7'b0, stretch_flag}, 8'h01);
    chk("R9 gen_irq", {7'b0, gen_irq}, 8'h01);
    host_sda = 1; tick(H); host_scl = 1; tick(H);
    chk("R9 SCL held low", {7'b0, scl_line}, 8'h00);
    chk("R10 nack level while held", {7'b0, sda_line}, 8'h01);
    cfg_ack_data = 0; tick(2);
    chk("R10 ack follows live bit", {7'b0, sda_line}, 8'h00);
    clr_stretch = 1; tick(1); clr_stretch = 0; tick(2);
    chk("R9 gen_irq holds with addr_flag", {7'b0, gen_irq}, 8'h01);
    wait (scl_line == 1'b1);
    tick(H/2); a = sda_line; tick(H/2);
    host_scl = 0; tick(H);
    chk("R10 ack after release", {7'b0, a}, 8'h00);
    clr_addr = 1; tick(1); clr_addr = 0; tick(2);
    chk("R9 gen_irq drops", {7'b0, gen_irq}, 8'h00);
    bus_stop();
    strobe_addr_start();
  endtask

  // R9: stretching disabled overrides hold enable
  task automatic t_nostretch();
    logic a;
    cfg_stretch_dis = 1;
    bus_start();
    send_byte(8'h68); // addr 0x34, write
    chk("R9 no stretch when disabled", {7'b0, stretch_flag}, 8'h00);
    ninth(a);
    chk("R9 ninth clock free, acked", {7'b0, a}, 8'h00);
    bus_stop();
    strobe_addr_start();
    cfg_hold_en = 0; cfg_stretch_dis = 0;
  endtask

  initial begin
    tick(5); rst_n = 1; tick(5);
    t_reset();
    t_direct();
    t_miss();
    t_masked();
    t_stretch();
    t_nostretch();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule